// File: doc/BRIEF.md
# SDRAM Command Timing and Refresh Scheduler

This block keeps the minimum spacings that a four-bank synchronous DRAM needs between commands, for a controller clocked at 7.5 ns. The controller reports each command it issues on one of six one-bit strobes (activate, read, write, precharge, refresh, mode set), together with a bank number. The block answers with ready flags for each bank and each command class. The controller may issue a command only in a cycle where the matching flag is high. All spacings are given in picoseconds and converted at elaboration into whole clock cycles, rounding up. The default values give the following counts: row-to-column 3, row active 6, precharge 3, row cycle 9, activate-to-activate across banks 2, write recovery 2, mode set 2 and refresh cycle 10.

Each bank runs a small state machine. Its states are `BANK_IDLE` and `BANK_OPEN`. An activate moves the bank from `BANK_IDLE` to `BANK_OPEN`, and a precharge moves it back to `BANK_IDLE`. Each bank also holds a set of saturating down-counters. A command loads a counter with its spacing minus one, and a command is ready once every counter that applies to it reads zero.

A global state machine covers the commands that lock the whole device. Its states are `GL_RUN`, `GL_REFRESH` and `GL_MODESET`. From `GL_RUN`, a refresh enters `GL_REFRESH` and a mode set enters `GL_MODESET`. Each busy state returns to `GL_RUN` when its cycle count runs out. While the machine is busy, every ready flag is held low.

A free-running interval timer fires once every 2083 cycles. Each firing moves the refresh request machine from `REQ_CLEAR` to `REQ_PENDING`. The machine returns to `REQ_CLEAR` when a refresh is issued.

Top module: `sdram_timing_sched`

## Requirements
- R1: `rw_ok[b]` (bit b belongs to bank b) is high only while bank b is open and at least 3 cycles have passed since its activate. A command issued in cycle n lets a ready flag rise in cycle n+T at the earliest.
- R2: `act_ok[b]` stays low until 9 cycles after the previous activate to bank b.
- R3: `act_ok[b]` is high only while bank b is closed, and only from 3 cycles after its precharge.
- R4: After an activate to bank b, `act_ok[b]` stays low until a precharge closes bank b. Once bank b is closed again, the flag follows the spacing rules of R2, R3 and R5.
- R5: After an activate to any bank, every bit of `act_ok` is low for the next cycle, so activates are at least 2 cycles apart.
- R6: `pre_ok[b]` is high only while bank b is open, and only from 6 cycles after its activate.
- R7: `pre_ok[b]` stays low until 2 cycles after the last write to bank b.
- R8: After a mode set, every ready output is low for 1 cycle. The ready outputs become valid again 2 cycles after the mode set.
- R9: `ref_ok` is high only when all banks are closed and at least 3 cycles have passed since each bank's precharge. After a refresh, every ready output is low until 10 cycles after it.
- R10: `refresh_due` rises in the cycle after each expiry of a fixed 2083-cycle timer. It stays high until a refresh is issued. The timer keeps running through refreshes. If a refresh coincides with an expiry, the expiry wins.
- R11: `mrs_ok` follows the same all-idle rule as `ref_ok`.
- R12: During reset and directly after it, all banks are closed. `act_ok` is all ones, `rw_ok` and `pre_ok` are zero, `ref_ok` and `mrs_ok` are high, and `refresh_due` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_act | input | 1 | Activate issued this cycle |
| cmd_rd | input | 1 | Read issued this cycle |
| cmd_wr | input | 1 | Write issued this cycle |
| cmd_pre | input | 1 | Precharge issued this cycle |
| cmd_ref | input | 1 | Refresh issued this cycle |
| cmd_mrs | input | 1 | Mode set issued this cycle |
| cmd_bank | input | 2 | Bank of the issued command |
| act_ok | output | 4 | Activate allowed, one bit per bank |
| rw_ok | output | 4 | Read or write allowed, one bit per bank |
| pre_ok | output | 4 | Precharge allowed, one bit per bank |
| ref_ok | output | 1 | Refresh allowed |
| mrs_ok | output | 1 | Mode set allowed |
| refresh_due | output | 1 | Refresh obligation pending |

## Verification
The assertions rely on the controller following the contract: at most one strobe is high in any cycle, and each command is issued only while its ready flag is high. A command issued outside that contract would break the checks on legal issue and on the busy window. The stimulus meets the contract by choosing commands from the bench's own reference model: a candidate command is issued only if the model reports it as allowed in that cycle. Some phases of the run are greedy and issue the first allowed command in every cycle, so that each spacing is exercised at its exact boundary. While `refresh_due` is pending, the stimulus closes banks and then issues the refresh.

// File: rtl/sdram_sched_pkg.sv
package sdram_sched_pkg;

    typedef enum logic {
        BANK_IDLE,
        BANK_OPEN
    } bank_state_e;

    typedef enum logic [1:0] {
        GL_RUN,
        GL_REFRESH,
        GL_MODESET
    } glob_state_e;

    typedef enum logic {
        REQ_CLEAR,
        REQ_PENDING
    } req_state_e;

    function automatic int ps_to_cyc(input int t_ps, input int clk_ps);
        return (t_ps + clk_ps - 1) / clk_ps;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sched_bank.sv
module sched_bank
    import sdram_sched_pkg::*;
#(
    parameter int CW    = 4,
    parameter int T_RCD = 3,
    parameter int T_RAS = 6,
    parameter int T_RP  = 3,
    parameter int T_RC  = 9,
    parameter int T_WR  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_hit,
    input  logic rw_hit,
    input  logic wr_hit,
    input  logic pre_hit,
    output logic is_open,
    output logic rp_clear,
    output logic act_ok,
    output logic rw_ok,
    output logic pre_ok
);
    localparam logic [CW-1:0] L_RCD = CW'(T_RCD - 1);
    localparam logic [CW-1:0] L_RAS = CW'(T_RAS - 1);
    localparam logic [CW-1:0] L_RP  = CW'(T_RP - 1);
    localparam logic [CW-1:0] L_RC  = CW'(T_RC - 1);
    localparam logic [CW-1:0] L_WR  = CW'(T_WR - 1);

    bank_state_e state, nstate;
    logic [CW-1:0] rcd_c, ras_c, rp_c, rc_c, wr_c;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= BANK_IDLE;
        else        state <= nstate;
    end

    always_comb begin
        nstate = state;
        unique case (state)
            BANK_IDLE: if (act_hit) nstate = BANK_OPEN;
            BANK_OPEN: if (pre_hit) nstate = BANK_IDLE;
            default:   nstate = BANK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rcd_c <= '0;
            ras_c <= '0;
            rp_c  <= '0;
            rc_c  <= '0;
            wr_c  <= '0;
        end else begin
            rcd_c <= act_hit ? L_RCD : ((rcd_c != '0) ? rcd_c - 1'b1 : rcd_c);
            ras_c <= act_hit ? L_RAS : ((ras_c != '0) ? ras_c - 1'b1 : ras_c);
            rc_c  <= act_hit ? L_RC  : ((rc_c  != '0) ? rc_c  - 1'b1 : rc_c);
            rp_c  <= pre_hit ? L_RP  : ((rp_c  != '0) ? rp_c  - 1'b1 : rp_c);
            wr_c  <= wr_hit  ? L_WR  : ((wr_c  != '0) ? wr_c  - 1'b1 : wr_c);
        end
    end

    always_comb begin
        act_ok = 1'b0;
        rw_ok  = 1'b0;
        pre_ok = 1'b0;
        unique case (state)
            BANK_IDLE: act_ok = (rp_c == '0) && (rc_c == '0);
            BANK_OPEN: begin
                rw_ok  = (rcd_c == '0);
                pre_ok = (ras_c == '0) && (wr_c == '0);
            end
            default: act_ok = 1'b0;
        endcase
    end

    assign is_open  = (state == BANK_OPEN);
    assign rp_clear = (rp_c == '0);

    AST_RCD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (act_hit && (T_RCD > 1)) |=> !rw_ok);                       // R1
    AST_RAS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (act_hit && (T_RAS > 1)) |=> !pre_ok);                      // R6
    AST_RP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_hit && (T_RP > 1)) |=> !act_ok);                       // R3
    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && (T_WR > 1)) |=> !pre_ok);                        // R7
    AST_OPEN_NO_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        act_hit |=> (is_open && !act_ok));                          // R4
    AST_ACT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        act_hit |-> act_ok);                                        // R2
    AST_RW_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        rw_hit |-> rw_ok);                                          // R1

endmodule

// File: rtl/sched_global.sv
module sched_global
    import sdram_sched_pkg::*;
#(
    parameter int CW    = 4,
    parameter int T_RRD = 2,
    parameter int T_RFC = 10,
    parameter int T_MRD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic any_act,
    input  logic ref_hit,
    input  logic mrs_hit,
    output logic busy,
    output logic rrd_clear
);
    localparam logic [CW-1:0] L_RRD = CW'(T_RRD - 1);
    localparam logic [CW-1:0] L_RFC = CW'(T_RFC - 1);
    localparam logic [CW-1:0] L_MRD = CW'(T_MRD - 1);

    glob_state_e state, nstate;
    logic [CW-1:0] lock_c, rrd_c;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= GL_RUN;
        else        state <= nstate;
    end

    always_comb begin
        nstate = state;
        unique case (state)
            GL_RUN: begin
                if (ref_hit)      nstate = GL_REFRESH;
                else if (mrs_hit) nstate = GL_MODESET;
            end
            GL_REFRESH: if (lock_c <= CW'(1)) nstate = GL_RUN;
            GL_MODESET: if (lock_c <= CW'(1)) nstate = GL_RUN;
            default:    nstate = GL_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_c <= '0;
            rrd_c  <= '0;
        end else begin
            if (ref_hit)            lock_c <= L_RFC;
            else if (mrs_hit)       lock_c <= L_MRD;
            else if (lock_c != '0)  lock_c <= lock_c - 1'b1;
            rrd_c <= any_act ? L_RRD : ((rrd_c != '0) ? rrd_c - 1'b1 : rrd_c);
        end
    end

    always_comb begin
        unique case (state)
            GL_RUN:     busy = 1'b0;
            GL_REFRESH: busy = 1'b1;
            GL_MODESET: busy = 1'b1;
            default:    busy = 1'b1;
        endcase
    end

    assign rrd_clear = (rrd_c == '0);

    AST_REF_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_hit && (T_RFC > 1)) |=> busy);                         // R9
    AST_MRS_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (mrs_hit && (T_MRD > 1)) |=> busy);                         // R8
    AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(any_act || ref_hit || mrs_hit));                 // R9
    AST_RRD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (any_act && (T_RRD > 1)) |=> !rrd_clear);                   // R5

endmodule

// File: rtl/sched_refresh_timer.sv
module sched_refresh_timer
    import sdram_sched_pkg::*;
#(
    parameter int REFI = 2083,
    parameter int TW   = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_hit,
    output logic due
);
    localparam logic [TW-1:0] L_REFI = TW'(REFI - 1);

    req_state_e state, nstate;
    logic [TW-1:0] tmr;
    logic tick;

    always_ff @(posedge clk) begin
        if (!rst_n)          tmr <= L_REFI;
        else if (tmr == '0)  tmr <= L_REFI;
        else                 tmr <= tmr - 1'b1;
    end

    assign tick = (tmr == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= REQ_CLEAR;
        else        state <= nstate;
    end

    always_comb begin
        nstate = state;
        unique case (state)
            REQ_CLEAR:   if (tick) nstate = REQ_PENDING;
            REQ_PENDING: if (ref_hit && !tick) nstate = REQ_CLEAR;
            default:     nstate = REQ_CLEAR;
        endcase
    end

    always_comb begin
        unique case (state)
            REQ_CLEAR:   due = 1'b0;
            REQ_PENDING: due = 1'b1;
            default:     due = 1'b0;
        endcase
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (due && !ref_hit) |=> due);                                 // R10
    AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (due && ref_hit && !tick) |=> !due);                        // R10
    AST_REQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> due);                                              // R10

endmodule

// File: rtl/sdram_timing_sched.sv
module sdram_timing_sched
    import sdram_sched_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int CLK_PS    = 7500,
    parameter int RCD_PS    = 20000,
    parameter int RAS_PS    = 45000,
    parameter int RP_PS     = 20000,
    parameter int RC_PS     = 67500,
    parameter int RRD_PS    = 15000,
    parameter int WR_PS     = 15000,
    parameter int MRD_PS    = 15000,
    parameter int RFC_PS    = 75000,
    parameter int REFI_PS   = 15625000,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_act,
    input  logic                 cmd_rd,
    input  logic                 cmd_wr,
    input  logic                 cmd_pre,
    input  logic                 cmd_ref,
    input  logic                 cmd_mrs,
    input  logic [BANK_W-1:0]    cmd_bank,
    output logic [NUM_BANKS-1:0] act_ok,
    output logic [NUM_BANKS-1:0] rw_ok,
    output logic [NUM_BANKS-1:0] pre_ok,
    output logic                 ref_ok,
    output logic                 mrs_ok,
    output logic                 refresh_due
);
    localparam int T_RCD    = ps_to_cyc(RCD_PS, CLK_PS);
    localparam int T_RAS    = ps_to_cyc(RAS_PS, CLK_PS);
    localparam int T_RP     = ps_to_cyc(RP_PS, CLK_PS);
    localparam int T_RC     = ps_to_cyc(RC_PS, CLK_PS);
    localparam int T_RRD    = ps_to_cyc(RRD_PS, CLK_PS);
    localparam int T_WR     = ps_to_cyc(WR_PS, CLK_PS);
    localparam int T_MRD    = ps_to_cyc(MRD_PS, CLK_PS);
    localparam int T_RFC    = ps_to_cyc(RFC_PS, CLK_PS);
    localparam int REFI_CYC = REFI_PS / CLK_PS;
    localparam int BANK_MAX = max2(max2(max2(T_RCD, T_RAS), max2(T_RP, T_RC)), T_WR);
    localparam int BANK_CW  = $clog2(BANK_MAX + 1);
    localparam int GLOB_CW  = $clog2(max2(max2(T_RFC, T_MRD), T_RRD) + 1);
    localparam int REF_TW   = $clog2(REFI_CYC + 1);

    logic [NUM_BANKS-1:0] b_open, b_rp_clear, b_act_ok, b_rw_ok, b_pre_ok;
    logic busy, rrd_clear, all_quiet;

    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
        logic sel;
        assign sel = (cmd_bank == BANK_W'(i));

        sched_bank #(
            .CW    (BANK_CW),
            .T_RCD (T_RCD),
            .T_RAS (T_RAS),
            .T_RP  (T_RP),
            .T_RC  (T_RC),
            .T_WR  (T_WR)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .act_hit  (cmd_act && sel),
            .rw_hit   ((cmd_rd || cmd_wr) && sel),
            .wr_hit   (cmd_wr && sel),
            .pre_hit  (cmd_pre && sel),
            .is_open  (b_open[i]),
            .rp_clear (b_rp_clear[i]),
            .act_ok   (b_act_ok[i]),
            .rw_ok    (b_rw_ok[i]),
            .pre_ok   (b_pre_ok[i])
        );

        assign act_ok[i] = b_act_ok[i] && rrd_clear && !busy;
        assign rw_ok[i]  = b_rw_ok[i]  && !busy;
        assign pre_ok[i] = b_pre_ok[i] && !busy;
    end

    sched_global #(
        .CW    (GLOB_CW),
        .T_RRD (T_RRD),
        .T_RFC (T_RFC),
        .T_MRD (T_MRD)
    ) u_global (
        .clk       (clk),
        .rst_n     (rst_n),
        .any_act   (cmd_act),
        .ref_hit   (cmd_ref),
        .mrs_hit   (cmd_mrs),
        .busy      (busy),
        .rrd_clear (rrd_clear)
    );

    sched_refresh_timer #(
        .REFI (REFI_CYC),
        .TW   (REF_TW)
    ) u_refresh (
        .clk     (clk),
        .rst_n   (rst_n),
        .ref_hit (cmd_ref),
        .due     (refresh_due)
    );

    assign all_quiet = (b_open == '0) && (&b_rp_clear) && !busy;
    assign ref_ok    = all_quiet;
    assign mrs_ok    = all_quiet;

    AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_act, cmd_rd, cmd_wr, cmd_pre, cmd_ref, cmd_mrs})); // R9
    AST_REF_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ref |-> (b_open == '0));                                 // R9
    AST_MRS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_mrs |-> (b_open == '0));                                 // R11
    AST_ACT_SPREAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_act && (T_RRD > 1)) |=> (act_ok == '0));                // R5

endmodule

// File: tb/sdram_timing_sched_test.sv
module sdram_timing_sched_test;
    localparam int NB    = 4;
    localparam int T_RCD = 3;
    localparam int T_RAS = 6;
    localparam int T_RP  = 3;
    localparam int T_RC  = 9;
    localparam int T_RRD = 2;
    localparam int T_WR  = 2;
    localparam int T_MRD = 2;
    localparam int T_RFC = 10;
    localparam int REFI  = 2083;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst_n;
    logic c_act, c_rd, c_wr, c_pre, c_ref, c_mrs;
    logic [1:0] c_bank;
    logic [NB-1:0] act_ok, rw_ok, pre_ok;
    logic ref_ok, mrs_ok, due;

    sdram_timing_sched uut (
        .clk(clk), .rst_n(rst_n),
        .cmd_act(c_act), .cmd_rd(c_rd), .cmd_wr(c_wr), .cmd_pre(c_pre),
        .cmd_ref(c_ref), .cmd_mrs(c_mrs), .cmd_bank(c_bank),
        .act_ok(act_ok), .rw_ok(rw_ok), .pre_ok(pre_ok),
        .ref_ok(ref_ok), .mrs_ok(mrs_ok), .refresh_due(due)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // behavioural reference: issue times per bank and globally
    int now = 0;
    int last_act[NB], last_pre[NB], last_wr[NB];
    bit m_open[NB];
    int last_any_act, last_ref, last_mrs;
    bit m_req;

    function automatic bit m_gok();
        return (now - last_ref >= T_RFC) && (now - last_mrs >= T_MRD);
    endfunction
    function automatic bit m_act(int b);
        return !m_open[b] && (now - last_pre[b] >= T_RP) && (now - last_act[b] >= T_RC)
               && (now - last_any_act >= T_RRD) && m_gok();
    endfunction
    function automatic bit m_rw(int b);
        return m_open[b] && (now - last_act[b] >= T_RCD) && m_gok();
    endfunction
    function automatic bit m_pre(int b);
        return m_open[b] && (now - last_act[b] >= T_RAS) && (now - last_wr[b] >= T_WR) && m_gok();
    endfunction
    function automatic bit m_idle();
        bit ok = m_gok();
        for (int b = 0; b < NB; b++)
            if (m_open[b] || (now - last_pre[b] < T_RP)) ok = 0;
        return ok;
    endfunction

    always @(posedge clk) begin
        if (rst_n) begin
            if (c_act) begin m_open[c_bank] = 1; last_act[c_bank] = now; last_any_act = now; end
            if (c_pre) begin m_open[c_bank] = 0; last_pre[c_bank] = now; end
            if (c_wr)  last_wr[c_bank] = now;
            if (c_ref) begin last_ref = now; m_req = 0; end
            if (c_mrs) last_mrs = now;
            if (now % REFI == REFI - 1) m_req = 1;
            now++;
        end
    end

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: got=%0h expected=%0h", tag, now, got, exp);
        end
    endtask

    task automatic compare_all();
        logic [NB-1:0] ea, er, ep;
        for (int b = 0; b < NB; b++) begin
            ea[b] = m_act(b);
            er[b] = m_rw(b);
            ep[b] = m_pre(b);
        end
        chk("R2/R3/R4/R5/R8/R9 act_ok", int'(act_ok), int'(ea));
        chk("R1/R8/R9 rw_ok", int'(rw_ok), int'(er));
        chk("R6/R7/R8/R9 pre_ok", int'(pre_ok), int'(ep));
        chk("R9 ref_ok", int'(ref_ok), int'(m_idle()));
        chk("R11 mrs_ok", int'(mrs_ok), int'(m_idle()));
        chk("R10 refresh_due", int'(due), int'(m_req));
    endtask

    task automatic clear_cmds();
        c_act = 0; c_rd = 0; c_wr = 0; c_pre = 0; c_ref = 0; c_mrs = 0; c_bank = 2'd0;
    endtask

    task automatic try_cmd(input int kind, input int b, output bit took);
        took = 0;
        c_bank = 2'(b);
        case (kind)
            0: if (m_act(b)) begin c_act = 1; took = 1; end
            1: if (m_rw(b))  begin c_rd = 1;  took = 1; end
            2: if (m_rw(b))  begin c_wr = 1;  took = 1; end
            3: if (m_pre(b)) begin c_pre = 1; took = 1; end
            4: if (m_idle()) begin c_ref = 1; took = 1; end
            5: if (m_idle()) begin c_mrs = 1; took = 1; end
            default: took = 0;
        endcase
    endtask

    task automatic pick(input bit greedy);
        bit took;
        clear_cmds();
        if (m_req) begin
            if (m_idle()) begin c_ref = 1; return; end
            for (int b = 0; b < NB; b++) begin
                try_cmd(3, b, took);
                if (took) return;
            end
            c_bank = 2'd0;
            return;
        end
        if (greedy) begin
            for (int k = 0; k < 24; k++) begin
                int idx = (k + now) % 24;
                try_cmd(idx / 4, idx % 4, took);
                if (took) return;
            end
            c_bank = 2'd0;
        end else begin
            int r = int'($urandom % 1024);
            try_cmd(r % 8, (r >> 3) % NB, took);
            if (!took) c_bank = 2'd0;
        end
    endtask

    initial begin
        for (int b = 0; b < NB; b++) begin
            last_act[b] = -1000; last_pre[b] = -1000; last_wr[b] = -1000; m_open[b] = 0;
        end
        last_any_act = -1000; last_ref = -1000; last_mrs = -1000; m_req = 0;
        clear_cmds();
        rst_n = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R12: reset state
        chk("R12 act_ok reset", int'(act_ok), 15);
        chk("R12 rw_ok reset", int'(rw_ok), 0);
        chk("R12 pre_ok reset", int'(pre_ok), 0);
        chk("R12 ref_ok reset", int'(ref_ok), 1);
        chk("R12 mrs_ok reset", int'(mrs_ok), 1);
        chk("R12 refresh_due reset", int'(due), 0);
        rst_n = 1;
        for (int i = 0; i < 9000; i++) begin
            @(negedge clk);
            compare_all();
            pick((i < 600) || (i >= 4000 && i < 4600) || (i >= 7000 && i < 7300));
        end
        @(negedge clk);
        clear_cmds();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R12: run did not finish, got=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule